// File: doc/BRIEF.md
# Register-Driven Block Copy Engine

This block copies a contiguous run of words from one memory region to another. Software sets it up through eight 32-bit registers: two region base addresses, a byte length, a direction flag, a trigger selector and an enable flag. It then writes a start command. The engine drives a single-word master port to fetch and store one word at a time, with a ready handshake on every access.

A start command only takes effect when the enable flag is already set and the engine is idle. When the last word has been stored, the engine writes back to its registers. Both base addresses move forward by the byte length. The length and start registers fall to zero. The enable flag is reloaded from the top bit of the old length, so a copy can leave the engine armed for the next one. A done bit is set in the status register, and the interrupt output pulses once.

The register port has a separate read strobe. Read data is registered and appears one clock after the strobe.

Top module: `blk_dma_engine`

## Requirements
- R1: After synchronous reset, every register reads zero, `mem_req` is low and `irq_done` is low.
- R2: Registers are selected by word index: 0 peripheral-side base address, 1 system-memory base address, 2 byte length, 3 direction (only bit 0 is kept), 4 trigger select (all 32 bits kept, no effect on the copy), 5 enable (only bit 0 is kept), 6 start/busy, 7 status (all 32 bits writable). Read data is valid on the clock after `reg_re`, and bits that are not kept read as zero.
- R3: A write to index 6 with bit 0 set starts a copy only when enable bit 0 is 1 and the engine is idle. Otherwise the write causes no memory access and no interrupt.
- R4: With direction bit 0 clear, words are read from the system-memory base and written to the peripheral-side base. With it set, the roles of the two bases are exchanged.
- R5: The word count is the length bits 30:2. Each word is one read followed by one write of the data that was read. Successive words use addresses 4 bytes higher. A count of zero completes with no memory access.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R7: On completion, both base addresses increase by length bits 30:0, and the length register becomes zero. Index 6 reads 0 once the engine is idle.
- R8: On completion, enable bit 0 takes the value that length bit 31 had before completion.
- R9: On completion, status bit 4 is set and the other status bits keep their values.
- R10: `irq_done` is high for exactly one cycle. For a non-empty copy, it is high in the second cycle after the final write is accepted.
- R11: While a copy runs, index 6 reads 1, and further start writes are ignored: there is no restart and no extra interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid one clock after `reg_re` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Access accepted at this clock edge |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default 32-bit data width. Each beat is therefore 4 bytes, and the word count is length bits 30:2. The bench holds a 256-word memory and a behavioural register model. It predicts every memory access and the exact cycle of the interrupt. It runs copies under both an always-ready memory and a randomly stalling memory. The stalls exercise the hold rule on the master port and make it possible to issue start writes in the middle of a copy. Zero-length copies, a copy that leaves the enable set, and a start while disabled are all covered.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] IDX_PADDR = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_SADDR = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_LEN   = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_DIR   = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_TSEL  = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_EN    = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_START = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_STAT  = 3'd7;

  localparam int DONE_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } mv_state_t;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int BEAT_SHIFT = 2,
  parameter int CNT_W      = REG_W - 1 - BEAT_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 busy,
  input  logic                 done_evt,
  output logic                 start_evt,
  output logic [REG_W-1:0]     periph_q,
  output logic [REG_W-1:0]     sys_q,
  output logic [CNT_W-1:0]     xfer_words,
  output logic                 dir_q,
  output logic                 en_q
);
  logic [REG_W-1:0] len_q;
  logic [REG_W-1:0] tsel_q;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] advance;
  logic [REG_W-1:0] rd_mux;

  assign advance    = {1'b0, len_q[REG_W-2:0]};
  assign xfer_words = len_q[REG_W-2:BEAT_SHIFT];
  assign start_evt  = reg_we && (reg_idx == IDX_START) && reg_wdata[0] && en_q && !busy;

  always_comb begin
    case (reg_idx)
      IDX_PADDR: rd_mux = periph_q;
      IDX_SADDR: rd_mux = sys_q;
      IDX_LEN:   rd_mux = len_q;
      IDX_DIR:   rd_mux = {{(REG_W-1){1'b0}}, dir_q};
      IDX_TSEL:  rd_mux = tsel_q;
      IDX_EN:    rd_mux = {{(REG_W-1){1'b0}}, en_q};
      IDX_START: rd_mux = {{(REG_W-1){1'b0}}, busy};
      default:   rd_mux = stat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      periph_q  <= '0;
      sys_q     <= '0;
      len_q     <= '0;
      dir_q     <= 1'b0;
      tsel_q    <= '0;
      en_q      <= 1'b0;
      stat_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_re) reg_rdata <= rd_mux;
      if (reg_we) begin
        case (reg_idx)
          IDX_PADDR: periph_q <= reg_wdata;
          IDX_SADDR: sys_q    <= reg_wdata;
          IDX_LEN:   len_q    <= reg_wdata;
          IDX_DIR:   dir_q    <= reg_wdata[0];
          IDX_TSEL:  tsel_q   <= reg_wdata;
          IDX_EN:    en_q     <= reg_wdata[0];
          IDX_STAT:  stat_q   <= reg_wdata;
          default:   ;
        endcase
      end
      // Completion write-back takes priority over a same-cycle software write.
      if (done_evt) begin
        periph_q         <= periph_q + advance;
        sys_q            <= sys_q + advance;
        len_q            <= '0;
        en_q             <= len_q[REG_W-1];
        stat_q[DONE_BIT] <= 1'b1;
      end
    end
  end

  p_len_clear_r7: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (len_q == '0));

  p_en_reload_r8: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (en_q == $past(len_q[REG_W-1])));

  p_status_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> stat_q[DONE_BIT]);

  p_busy_read_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_re && reg_idx == IDX_START) |=> reg_rdata[0]);
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_SHIFT = 2,
  parameter int CNT_W      = DATA_W - 1 - BEAT_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              dir,
  input  logic [DATA_W-1:0] periph_addr,
  input  logic [DATA_W-1:0] sys_addr,
  input  logic [CNT_W-1:0]  words,
  output logic              busy,
  output logic              done_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              irq
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(1 << BEAT_SHIFT);

  mv_state_t         st_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] dst_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              irq_q;

  assign busy      = (st_q != ST_IDLE);
  assign done_evt  = (st_q == ST_FIN);
  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= (st_q == ST_FIN);
      case (st_q)
        ST_IDLE: if (start_evt) begin
          src_q <= dir ? periph_addr : sys_addr;
          dst_q <= dir ? sys_addr : periph_addr;
          cnt_q <= words;
          st_q  <= (words == '0) ? ST_FIN : ST_RD;
        end
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          src_q <= src_q + STEP;
          dst_q <= dst_q + STEP;
          cnt_q <= cnt_q - CNT_W'(1);
          st_q  <= (cnt_q == CNT_W'(1)) ? ST_FIN : ST_RD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WR && mem_ready && cnt_q != CNT_W'(1)) |=> (st_q == ST_RD && src_q == $past(src_q) + STEP));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_write_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD && mem_ready) |=> (mem_we && mem_wdata == $past(mem_rdata)));
endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ready,
  output logic                 irq_done
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int CNT_W      = DATA_W - 1 - BEAT_SHIFT;

  logic              busy;
  logic              done_evt;
  logic              start_evt;
  logic [DATA_W-1:0] periph_q;
  logic [DATA_W-1:0] sys_q;
  logic [CNT_W-1:0]  xfer_words;
  logic              dir_q;
  logic              en_q;

  dma_regfile #(
    .REG_W(DATA_W), .BEAT_SHIFT(BEAT_SHIFT), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done_evt(done_evt),
    .start_evt(start_evt), .periph_q(periph_q), .sys_q(sys_q),
    .xfer_words(xfer_words), .dir_q(dir_q), .en_q(en_q)
  );

  dma_mover #(
    .DATA_W(DATA_W), .BEAT_SHIFT(BEAT_SHIFT), .CNT_W(CNT_W)
  ) u_mover (
    .clk(clk), .rst(rst), .start_evt(start_evt), .dir(dir_q),
    .periph_addr(periph_q), .sys_addr(sys_q), .words(xfer_words),
    .busy(busy), .done_evt(done_evt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq(irq_done)
  );

  p_start_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx == IDX_START && !en_q && !busy) |=> !mem_req);

  p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_evt) |=> busy);
endmodule

// File: tb/blk_dma_engine_tb.sv
`timescale 1ns/1ps
module blk_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, irq_done;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  blk_dma_engine u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq_done(irq_done)
  );

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } txn_t;
  txn_t expq[$];
  logic [31:0] mem [0:255];

  int errors = 0, checks = 0, cyc = 0, irq_due = -1, irq_count = 0;
  bit zl_armed = 0, rand_ready = 0;
  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;
  logic prev_we = 1'b0;

  // Behavioural register model
  logic [31:0] m_periph = 0, m_sys = 0, m_len = 0, m_tsel = 0, m_stat = 0;
  bit m_dir = 0, m_en = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder and per-clock comparison against the expected queue
  always @(negedge clk) begin
    txn_t t;
    if (!rst) begin
      if (prev_stall)
        check(mem_req && mem_we == prev_we && mem_addr == prev_addr, "R6 hold while stalled", mem_addr, prev_addr);
      mem_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      mem_rdata = mem[mem_addr[9:2]];
      prev_stall = mem_req && !mem_ready;
      prev_addr = mem_addr;
      prev_we = mem_we;
      if (mem_req && mem_ready) begin
        if (expq.size() == 0) check(0, "R3 R11 unexpected access", mem_addr, 32'h0);
        else begin
          t = expq.pop_front();
          check(mem_we == t.we && mem_addr == t.addr, "R4 R5 access order", mem_addr, t.addr);
          if (t.we) begin
            check(mem_wdata == t.data, "R5 write data", mem_wdata, t.data);
            mem[mem_addr[9:2]] = mem_wdata;
            if (expq.size() == 0) irq_due = cyc + 2;
          end
        end
      end
      if (irq_done) begin
        irq_count++;
        check(cyc == irq_due || zl_armed, "R10 irq timing", cyc, irq_due);
        zl_armed = 0;
      end else if (cyc == irq_due) check(0, "R10 irq missing", 32'h0, 32'h1);
    end else begin
      check(!mem_req && !irq_done, "R1 outputs idle in reset", {30'b0, mem_req, irq_done}, 32'h0);
    end
    cyc++;
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_idx = idx;
    @(negedge clk);
    d = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic set_reg(input logic [2:0] idx, input logic [31:0] d);
    wr(idx, d);
    case (idx)
      3'd0: m_periph = d;
      3'd1: m_sys = d;
      3'd2: m_len = d;
      3'd3: m_dir = d[0];
      3'd4: m_tsel = d;
      3'd5: m_en = d[0];
      3'd7: m_stat = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_reg(input logic [2:0] idx);
    case (idx)
      3'd0: return m_periph;
      3'd1: return m_sys;
      3'd2: return m_len;
      3'd3: return {31'b0, m_dir};
      3'd4: return m_tsel;
      3'd5: return {31'b0, m_en};
      3'd6: return 32'h0;
      default: return m_stat;
    endcase
  endfunction

  task automatic check_regs(input string req);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check(v == exp_reg(3'(i)), req, v, exp_reg(3'(i)));
    end
  endtask

  // Start command: the model predicts the access list when the copy should run
  task automatic do_start();
    logic [31:0] src, dst;
    int words;
    if (m_en) begin
      src = m_dir ? m_periph : m_sys;
      dst = m_dir ? m_sys : m_periph;
      words = int'(m_len[30:2]);
      for (int i = 0; i < words; i++) begin
        expq.push_back('{1'b0, src + 32'(4*i), 32'h0});
        expq.push_back('{1'b1, dst + 32'(4*i), mem[(src[9:2] + 8'(i))]});
      end
      if (words == 0) zl_armed = 1;
    end
    wr(3'd6, 32'h1);
  endtask

  task automatic wait_done(input string req);
    int start_cnt = irq_count;
    int n = 0;
    while (irq_count == start_cnt && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(irq_count == start_cnt + 1, req, irq_count, start_cnt + 1);
    m_periph = m_periph + {1'b0, m_len[30:0]};
    m_sys = m_sys + {1'b0, m_len[30:0]};
    m_en = m_len[31];
    m_len = 0;
    m_stat = m_stat | 32'h10;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + 32'(i * 7);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_regs("R1 reset value");

    // R2: register storage and masking
    set_reg(3'd0, 32'h0000_0200);
    set_reg(3'd1, 32'h0000_0040);
    set_reg(3'd3, 32'hFFFF_FFFE);
    set_reg(3'd4, 32'h1234_5678);
    set_reg(3'd7, 32'h0000_0003);
    set_reg(3'd2, 32'h0000_0010);
    check_regs("R2 readback");

    // R3: start while disabled does nothing
    cnt0 = irq_count;
    do_start();
    repeat (10) @(negedge clk);
    check(irq_count == cnt0, "R3 no irq when disabled", irq_count, cnt0);
    rd(3'd6, v);
    check(v == 32'h0, "R3 start stays idle", v, 32'h0);

    // R4 R5 R7 R9: forward copy, enable dropped afterwards (R8)
    set_reg(3'd5, 32'h0000_00FF);
    rand_ready = 1;
    do_start();
    rd(3'd6, v);
    check(v == 32'h1, "R11 busy reads 1", v, 32'h1);
    wr(3'd6, 32'h1);
    wait_done("R7 completion");
    repeat (20) @(negedge clk);
    check(irq_count == cnt0 + 1, "R11 start while busy ignored", irq_count, cnt0 + 1);
    check(expq.size() == 0, "R5 all accesses made", expq.size(), 0);
    check_regs("R7 R8 R9 post-copy registers");

    // R4: reversed direction, bit 31 keeps the engine armed (R8)
    set_reg(3'd3, 32'h1);
    set_reg(3'd0, 32'h0000_0300);
    set_reg(3'd1, 32'h0000_0080);
    set_reg(3'd2, 32'h8000_000C);
    set_reg(3'd5, 32'h1);
    do_start();
    wait_done("R4 reverse completion");
    check_regs("R8 enable kept by bit 31");

    // R5: zero length completes without memory access, always-ready memory
    rand_ready = 0;
    set_reg(3'd7, 32'h0000_0100);
    set_reg(3'd2, 32'h8000_0000);
    do_start();
    wait_done("R5 zero length completion");
    check(expq.size() == 0, "R5 zero length no access", expq.size(), 0);
    check_regs("R9 status bits kept");

    // R4: direction 0 again, back-to-back ready, 5 words
    set_reg(3'd3, 32'h0);
    set_reg(3'd1, 32'h0000_0100);
    set_reg(3'd0, 32'h0000_0380);
    set_reg(3'd2, 32'h0000_0014);
    do_start();
    wait_done("R10 fast copy completion");
    check_regs("R7 final registers");
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule